// File: doc/BRIEF.md
# Byte-Wide Indirect Register Microport

A host with an 8-bit data bus and a 3-bit address reaches a bank of 32-bit per-channel registers through eight external locations. The host selects a channel and an internal register address by writing two dedicated locations. It then moves the register contents one byte at a time through four data locations.

Reading data byte 0 copies the whole selected internal word into a set of interface holding bytes. Bytes 1 to 3 are then served from that copy, so a multi-byte read stays coherent even if the selection or the register changes in between. Writes go the other way. Bytes 0 to 2 are staged in the same holding bytes, and writing byte 3 commits all four bytes to the selected register in one cycle. Because the holding bytes are shared, a read of byte 0 followed by a write of byte 3 performs a read-modify-write of the top byte.

Each of the four channels holds one oscillator frequency word at internal address 0x02.

The strobes are sampled synchronously. The port never stalls, and there is no back-pressure: every strobed access completes in the cycle it is presented, and read data is registered.

Top module: `hostport_indirect_regs`

## Requirements
- R1: After reset, the channel latch, the address latch, the holding bytes, every channel's frequency word and rdata are all zero.
- R2: A write to external address 7 loads the channel latch, and a write to address 6 loads the internal address latch. Both read back at their own address. Addresses 4 and 5 read zero, and writes to them change nothing.
- R3: An access takes effect only when cs is high together with rd or wr. rdata is loaded at the clock edge that samples a read and holds its value otherwise.
- R4: A read of address 0 returns bits 7:0 of the live selected word and copies all 32 bits into the holding bytes. Reads of addresses 1, 2 and 3 return holding bits 15:8, 23:16 and 31:24, unaffected by later selection changes.
- R5: Writes to addresses 0, 1 and 2 only stage a holding byte. A write to address 3 commits {wdata, holding byte 2, byte 1, byte 0} to the selected register in that cycle.
- R6: Channels 0 to 3 each own an independent frequency word at internal address 0x02.
- R7: A channel value of 4 or more selects nothing: the data word reads as zero and commits are dropped.
- R8: Any internal address other than 0x02 reads as zero and ignores commits.
- R9: After a read of address 0, a write of address 3 commits the captured bytes 0 to 2 with the new top byte.
- R10: When rd and wr both hit address 0 in one cycle, rdata gets the live byte 0, holding byte 0 takes wdata, and holding bytes 1 to 3 take the live word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, qualifies rd and wr |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | External location |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |

## Verification
The snapshot of byte 0 and the staging of a write byte both load the holding bytes, so they can fall in the same cycle. The bench provokes this by asserting rd and wr together at address 0 with a value that differs from the live low byte. It judges the outcome in three ways: the returned byte must be the old live value, a following read of byte 1 must return the captured word, and a commit through byte 3 must carry the new low byte. The byte 3 commit after a snapshot is judged the same way, by reading back the merged word.

// File: rtl/hpir_pkg.sv
package hpir_pkg;
  // External location map; positions matter to the host software.
  localparam int EXT_AW      = 3;
  localparam int LOC_CHAN    = 7;
  localparam int LOC_IADDR   = 6;
  localparam int BYTE_W      = 8;
  localparam int WORD_BYTES  = 4;
  localparam int WORD_W      = BYTE_W * WORD_BYTES;
  localparam int IDX_W       = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    LOC_K_DATA   = 2'd0,
    LOC_K_ADDR   = 2'd1,
    LOC_K_SEL    = 2'd2,
    LOC_K_UNUSED = 2'd3
  } loc_kind_e;
endpackage

// File: rtl/hpir_decode.sv
module hpir_decode
  import hpir_pkg::*;
(
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [EXT_AW-1:0] addr,
  output logic              rd_en,
  output logic              wr_en,
  output loc_kind_e         kind,
  output logic [IDX_W-1:0]  byte_idx
);
  assign rd_en    = cs & rd;
  assign wr_en    = cs & wr;
  assign byte_idx = addr[IDX_W-1:0];

  always_comb begin
    if (int'(addr) < WORD_BYTES)       kind = LOC_K_DATA;
    else if (int'(addr) == LOC_CHAN)   kind = LOC_K_SEL;
    else if (int'(addr) == LOC_IADDR)  kind = LOC_K_ADDR;
    else                               kind = LOC_K_UNUSED;
  end
endmodule

// File: rtl/hpir_holding.sv
module hpir_holding
  import hpir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_en,
  input  logic              stage_en,
  input  logic [IDX_W-1:0]  stage_idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [WORD_W-1:0] live_word,
  output logic [WORD_W-1:0] hold_q,
  output logic [WORD_W-1:0] commit_word
);
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        hold_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (stage_en && int'(stage_idx) == b)
        hold_q[b*BYTE_W +: BYTE_W] <= wdata;
      else if (snap_en)
        hold_q[b*BYTE_W +: BYTE_W] <= live_word[b*BYTE_W +: BYTE_W];
    end

    if (b == WORD_BYTES - 1) begin : g_top
      assign commit_word[b*BYTE_W +: BYTE_W] = wdata;
    end else begin : g_low
      assign commit_word[b*BYTE_W +: BYTE_W] = hold_q[b*BYTE_W +: BYTE_W];
    end
  end

  assert_snapshot_whole_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en && !stage_en |=> hold_q == $past(live_word));

  assert_collision_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en && stage_en && stage_idx == '0 |=>
      hold_q[BYTE_W-1:0] == $past(wdata) &&
      hold_q[WORD_W-1:BYTE_W] == $past(live_word[WORD_W-1:BYTE_W]));
endmodule

// File: rtl/hpir_regfile.sv
module hpir_regfile
  import hpir_pkg::*;
#(
  parameter int          NUM_CH    = 4,
  parameter logic [7:0]  FREQ_ADDR = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] chan,
  input  logic [BYTE_W-1:0] iaddr,
  input  logic              commit,
  input  logic [WORD_W-1:0] commit_word,
  output logic [WORD_W-1:0] live_word
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [BYTE_W-1:0] NUM_CH_V = BYTE_W'(NUM_CH);

  logic               chan_ok;
  logic               addr_ok;
  logic [WORD_W-1:0]  freq_q [NUM_CH];

  assign chan_ok = chan < NUM_CH_V;
  assign addr_ok = iaddr == FREQ_ADDR;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = commit && chan_ok && addr_ok && int'(chan) == c;

    always_ff @(posedge clk) begin
      if (!rst_n)   freq_q[c] <= '0;
      else if (hit) freq_q[c] <= commit_word;
    end

    assert_word_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && int'(chan) == c && iaddr == FREQ_ADDR) |=> $stable(freq_q[c]));
  end

  always_comb begin
    live_word = '0;
    if (chan_ok && addr_ok) live_word = freq_q[chan[CH_W-1:0]];
  end
endmodule

// File: rtl/hostport_indirect_regs.sv
module hostport_indirect_regs
  import hpir_pkg::*;
#(
  parameter int         NUM_CH    = 4,
  parameter logic [7:0] FREQ_ADDR = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [EXT_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam logic [BYTE_W-1:0] NUM_CH_V = BYTE_W'(NUM_CH);

  logic              rd_en, wr_en;
  loc_kind_e         kind;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] chan_q, iaddr_q, rd_byte;
  logic [WORD_W-1:0] live_word, hold_q, commit_word;
  logic              snap_en, stage_en, commit;

  hpir_decode u_dec (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .kind(kind), .byte_idx(byte_idx)
  );

  assign snap_en  = rd_en && kind == LOC_K_DATA && byte_idx == '0;
  assign stage_en = wr_en && kind == LOC_K_DATA;
  assign commit   = stage_en && int'(byte_idx) == WORD_BYTES - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q  <= '0;
      iaddr_q <= '0;
    end else if (wr_en) begin
      if (kind == LOC_K_SEL)  chan_q  <= wdata;
      if (kind == LOC_K_ADDR) iaddr_q <= wdata;
    end
  end

  hpir_holding u_hold (
    .clk(clk), .rst_n(rst_n), .snap_en(snap_en), .stage_en(stage_en),
    .stage_idx(byte_idx), .wdata(wdata), .live_word(live_word),
    .hold_q(hold_q), .commit_word(commit_word)
  );

  hpir_regfile #(.NUM_CH(NUM_CH), .FREQ_ADDR(FREQ_ADDR)) u_rf (
    .clk(clk), .rst_n(rst_n), .chan(chan_q), .iaddr(iaddr_q),
    .commit(commit), .commit_word(commit_word), .live_word(live_word)
  );

  always_comb begin
    unique case (kind)
      LOC_K_DATA:   rd_byte = (byte_idx == '0) ? live_word[BYTE_W-1:0]
                                               : hold_q[byte_idx*BYTE_W +: BYTE_W];
      LOC_K_SEL:    rd_byte = chan_q;
      LOC_K_ADDR:   rd_byte = iaddr_q;
      default:      rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_byte;
  end

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_chan_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && int'(addr) == LOC_CHAN |=> chan_q == $past(wdata));

  assert_bad_chan_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == '0 && chan_q >= NUM_CH_V |=> rdata == '0);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == '0 && iaddr_q != FREQ_ADDR |=> rdata == '0);
endmodule

// File: tb/hostport_indirect_regs_tb.sv
module hostport_indirect_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  hostport_indirect_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // {is_read, addr, wdata, expected}
  localparam int NV = 33;
  localparam logic [19:0] VECS [NV] = '{
    {1'b0,3'd7,8'h01,8'h00}, {1'b0,3'd6,8'h02,8'h00},           // R2
    {1'b0,3'd0,8'h78,8'h00}, {1'b0,3'd1,8'h56,8'h00},           // R5
    {1'b0,3'd2,8'h34,8'h00}, {1'b0,3'd3,8'h12,8'h00},
    {1'b1,3'd0,8'h00,8'h78}, {1'b1,3'd1,8'h00,8'h56},           // R4
    {1'b1,3'd2,8'h00,8'h34}, {1'b1,3'd3,8'h00,8'h12},
    {1'b1,3'd7,8'h00,8'h01}, {1'b1,3'd6,8'h00,8'h02},           // R2
    {1'b0,3'd7,8'h02,8'h00}, {1'b1,3'd0,8'h00,8'h00},           // R6
    {1'b0,3'd0,8'hAA,8'h00}, {1'b0,3'd1,8'hBB,8'h00},
    {1'b0,3'd2,8'hCC,8'h00}, {1'b0,3'd3,8'hDD,8'h00},
    {1'b1,3'd0,8'h00,8'hAA}, {1'b1,3'd3,8'h00,8'hDD},
    {1'b0,3'd7,8'h01,8'h00}, {1'b1,3'd0,8'h00,8'h78},           // R6
    {1'b1,3'd2,8'h00,8'h34},
    {1'b1,3'd4,8'h00,8'h00}, {1'b0,3'd5,8'hFF,8'h00},           // R2
    {1'b1,3'd5,8'h00,8'h00},
    {1'b0,3'd7,8'h03,8'h00}, {1'b0,3'd0,8'h11,8'h00},           // R5
    {1'b0,3'd1,8'h22,8'h00}, {1'b0,3'd2,8'h33,8'h00},
    {1'b1,3'd1,8'h00,8'h22}, {1'b1,3'd0,8'h00,8'h00},
    {1'b1,3'd2,8'h00,8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: rdata=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic r, input logic w, input logic [2:0] a,
                        input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; rd = r; wr = w; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic wr_b(input logic [2:0] a, input logic [7:0] d);
    access(1'b0, 1'b1, a, d);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    access(1'b1, 1'b0, a, 8'h00);
    check(req, rdata, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 8'h00);
    rd_chk("R1 channel latch", 3'd7, 8'h00);
    rd_chk("R1 address latch", 3'd6, 8'h00);
    wr_b(3'd6, 8'h02);
    rd_chk("R1 channel 0 word", 3'd0, 8'h00);
    rd_chk("R1 holding byte 3", 3'd3, 8'h00);
    wr_b(3'd6, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][19]) begin
        access(1'b1, 1'b0, VECS[i][18:16], 8'h00);
        check($sformatf("R2/R4/R5/R6 table vector %0d", i), rdata, VECS[i][7:0]);
      end else begin
        wr_b(VECS[i][18:16], VECS[i][15:8]);
      end
    end

    // R3: no read, rdata holds; strobes without cs are ignored
    rd_chk("R3 read channel", 3'd7, 8'h03);
    repeat (3) @(negedge clk);
    check("R3 idle hold", rdata, 8'h03);
    access(1'b1, 1'b0, 3'd6, 8'h00, 1'b0);
    check("R3 read without cs", rdata, 8'h03);
    access(1'b0, 1'b1, 3'd7, 8'h01, 1'b0);
    rd_chk("R3 write without cs", 3'd7, 8'h03);

    // R4: snapshot survives a channel change
    wr_b(3'd7, 8'h01);
    rd_chk("R4 snapshot ch1", 3'd0, 8'h78);
    wr_b(3'd7, 8'h02);
    rd_chk("R4 byte1 from snapshot", 3'd1, 8'h56);
    rd_chk("R4 byte3 from snapshot", 3'd3, 8'h12);
    rd_chk("R4 new snapshot ch2", 3'd0, 8'hAA);
    rd_chk("R4 ch2 byte3", 3'd3, 8'hDD);

    // R7: out-of-range channel
    wr_b(3'd7, 8'h04);
    rd_chk("R7 channel 4 reads zero", 3'd0, 8'h00);
    rd_chk("R7 channel 4 snapshot zero", 3'd2, 8'h00);
    wr_b(3'd0, 8'h01); wr_b(3'd1, 8'h02); wr_b(3'd2, 8'h03); wr_b(3'd3, 8'h04);
    wr_b(3'd7, 8'h00);
    rd_chk("R7 ch0 untouched", 3'd0, 8'h00);
    wr_b(3'd7, 8'h03);
    rd_chk("R7 ch3 untouched", 3'd0, 8'h00);
    wr_b(3'd7, 8'h01);
    rd_chk("R7 ch1 untouched", 3'd0, 8'h78);
    wr_b(3'd7, 8'h02);
    rd_chk("R7 ch2 untouched", 3'd0, 8'hAA);
    wr_b(3'd7, 8'hFF);
    rd_chk("R7 channel FF readback", 3'd7, 8'hFF);
    rd_chk("R7 channel FF word", 3'd0, 8'h00);

    // R8: unmapped internal address
    wr_b(3'd7, 8'h01);
    wr_b(3'd6, 8'h05);
    rd_chk("R8 unmapped reads zero", 3'd0, 8'h00);
    wr_b(3'd0, 8'h55); wr_b(3'd1, 8'h66); wr_b(3'd2, 8'h77); wr_b(3'd3, 8'h88);
    rd_chk("R8 unmapped still zero", 3'd0, 8'h00);
    rd_chk("R8 address readback", 3'd6, 8'h05);
    wr_b(3'd6, 8'h02);
    rd_chk("R8 mapped word intact low", 3'd0, 8'h78);
    rd_chk("R8 mapped word intact high", 3'd3, 8'h12);

    // R9: read-modify-write of the top byte
    rd_chk("R9 snapshot", 3'd0, 8'h78);
    wr_b(3'd3, 8'h9A);
    rd_chk("R9 low byte kept", 3'd0, 8'h78);
    rd_chk("R9 byte1 kept", 3'd1, 8'h56);
    rd_chk("R9 top byte new", 3'd3, 8'h9A);

    // R10: read and write of byte 0 in one cycle
    access(1'b1, 1'b1, 3'd0, 8'hEE);
    check("R10 rdata is live byte0", rdata, 8'h78);
    rd_chk("R10 byte1 snapshot", 3'd1, 8'h56);
    wr_b(3'd3, 8'h9A);
    rd_chk("R10 staged byte0 committed", 3'd0, 8'hEE);
    rd_chk("R10 byte2 from live", 3'd2, 8'h34);

    finish_run();
  end
endmodule